// File: doc/BRIEF.md
# Frequency-Select Strap Latch Controller

This block sits between the board-level strap pins of a clock synthesizer and its PLL and divider control. A combined strobe pin carries an active-low power-good indication from the processor supply. The first time that strobe is seen low in a qualified way, the block captures the frequency-select straps, the 24/48 MHz output select and a three-level "test" indication in one shot. From then on the captured values are frozen and the same strobe pin is read as a live, active-high power-down request.

The captured straps are decoded into a CPU frequency code, an invalid-select flag, the 24/48 MHz choice and the test-mode controls. In test mode the test behaviour select stays live, so the tester can switch between tri-stated outputs and reference-divided outputs without resetting the part. All pins pass through a two-flop synchronizer before use. The SRC frequency is 100 MHz for every normal-mode code and needs no output from this block. Analog level sensing, the PLLs and the dividers are outside the block.

Top module: `fsel_strap_latch`

## Requirements
- R1: While reset is asserted and after it is released, and before any latch event: `locked`=0, `pd_req`=0, `test_mode`=0, `test_refdiv`=0, `sel_invalid`=0, `clk24_sel`=0 and `cpu_freq_code`=0 (the 100 MHz code).
- R2: A latch event needs the synchronized strobe low on two consecutive clocks. When `pwrgd_pd_n` falls just after a rising edge and stays low, `locked` rises after the fourth rising edge. A strobe low for one clock cycle only causes no latch.
- R3: Once `locked` is 1 it stays 1 until reset. Later changes on `fs_pins`, `sel_24_48`, `fsc_high` and on the strobe leave `cpu_freq_code`, `sel_invalid`, `clk24_sel` and `test_mode` unchanged.
- R4: Before the latch event `pd_req` is 0 whatever the strobe does. After it, `pd_req` follows the strobe level (1 = power down) with two clocks of synchronizer delay.
- R5: With `fs_pins[3:0]` = {D,C,B,A} latched in normal mode, `cpu_freq_code` is: 0101→0 (100 MHz), 0001→1 (133.33), 0011→2 (166.67), 0010→3 (200), 0000→4 (266.67), 0100→5 (333.33), 0110→6 (400). `fs_pins[4]` (FS_E) has no effect on the code.
- R6: Any other normal-mode {D,C,B,A} value gives `cpu_freq_code`=0 and `sel_invalid`=1. The seven listed values give `sel_invalid`=0.
- R7: `clk24_sel` equals the latched `sel_24_48`: 0 selects 48 MHz and 1 selects 24 MHz.
- R8: If `fsc_high` is 1 at the latch event, `test_mode`=1, `cpu_freq_code`=0 and `sel_invalid`=0. While in test mode, `test_refdiv` follows the live synchronized FS_B (`fs_pins[1]`): 0 means tri-stated outputs and 1 means reference-divided outputs. Outside test mode `test_refdiv` is 0.
- R9: Asserting reset after a latch event returns the block to the unlatched state of R1. A new qualified strobe low then latches new strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fs_pins | input | 5 | Frequency-select straps, bit 0 = FS_A up to bit 4 = FS_E |
| sel_24_48 | input | 1 | 24/48 MHz output select strap |
| fsc_high | input | 1 | FS_C sensed at its high (test) level |
| pwrgd_pd_n | input | 1 | Power-good strobe (active low) before latch, power-down (active high) after |
| cpu_freq_code | output | 3 | Decoded CPU frequency code |
| sel_invalid | output | 1 | Latched select combination not in the table |
| clk24_sel | output | 1 | 1 = 24 MHz, 0 = 48 MHz |
| test_mode | output | 1 | Test mode latched |
| test_refdiv | output | 1 | Test behaviour: 1 = reference-divided, 0 = tri-state |
| pd_req | output | 1 | Power-down request |
| locked | output | 1 | Straps have been latched |

## Verification
On every cycle the assertions check that `locked` never falls and that the captured straps never move once locked. They also check that no power-down request appears before the latch, that a lock follows two low synchronized strobe samples, and that the invalid flag and test mode always leave the code at its default. Only the bench scenarios show the decode values for each select pattern and the exact latency of the latch and the power-down path. The same holds for rejecting a one-cycle strobe glitch, the live FS_B tracking in test mode and relocking after reset.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  localparam int FS_W = 5;

  typedef enum logic [2:0] {
    CPU_100 = 3'd0,
    CPU_133 = 3'd1,
    CPU_166 = 3'd2,
    CPU_200 = 3'd3,
    CPU_266 = 3'd4,
    CPU_333 = 3'd5,
    CPU_400 = 3'd6
  } cpu_freq_e;

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            sel24;
    logic            tst;
  } straps_t;

  localparam int STRAPS_W = $bits(straps_t);
endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] stage_d;
      if (i == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_rest
        assign stage_d = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fsl_capture.sv
module fsl_capture
  import fsl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe_s,
  input  straps_t straps_s,
  output straps_t straps_q,
  output logic    locked,
  output logic    pd_req
);
  logic    low_seen_q, low_seen_d;
  logic    locked_q, locked_d;
  straps_t straps_d;
  logic    latch_en;

  always_comb begin
    latch_en   = !strobe_s && low_seen_q && !locked_q;
    low_seen_d = !strobe_s;
    locked_d   = locked_q | latch_en;
    straps_d   = latch_en ? straps_s : straps_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_seen_q <= 1'b0;
      locked_q   <= 1'b0;
      straps_q   <= '0;
    end else begin
      low_seen_q <= low_seen_d;
      locked_q   <= locked_d;
      straps_q   <= straps_d;
    end
  end

  assign locked = locked_q;
  assign pd_req = locked_q & strobe_s;

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

  // R3
  straps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(straps_q));

  // R2
  lock_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> ($past(strobe_s) == 1'b0 && $past(low_seen_q) == 1'b1));

  // R4
  no_early_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> !pd_req);
endmodule

// File: rtl/fsl_decode.sv
module fsl_decode
  import fsl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      locked,
  input  straps_t   straps_q,
  input  logic      live_fsb,
  output cpu_freq_e code,
  output logic      invalid,
  output logic      clk24_sel,
  output logic      test_mode,
  output logic      test_refdiv
);
  logic [3:0] dcba;
  logic       normal;

  always_comb begin
    dcba        = straps_q.fs[3:0];
    test_mode   = locked && straps_q.tst;
    normal      = locked && !straps_q.tst;
    clk24_sel   = locked && straps_q.sel24;
    test_refdiv = test_mode && live_fsb;
    code        = CPU_100;
    invalid     = 1'b0;
    if (normal) begin
      unique case (dcba)
        4'b0101: code = CPU_100;
        4'b0001: code = CPU_133;
        4'b0011: code = CPU_166;
        4'b0010: code = CPU_200;
        4'b0000: code = CPU_266;
        4'b0100: code = CPU_333;
        4'b0110: code = CPU_400;
        default: begin
          code    = CPU_100;
          invalid = 1'b1;
        end
      endcase
    end
  end

  // R6
  invalid_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (code == CPU_100 && !test_mode));

  // R8
  test_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (code == CPU_100 && !invalid));

  // R8
  refdiv_only_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_refdiv |-> test_mode);
endmodule

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] fs_pins,
  input  logic       sel_24_48,
  input  logic       fsc_high,
  input  logic       pwrgd_pd_n,
  output logic [2:0] cpu_freq_code,
  output logic       sel_invalid,
  output logic       clk24_sel,
  output logic       test_mode,
  output logic       test_refdiv,
  output logic       pd_req,
  output logic       locked
);
  localparam int SYNC_W = STRAPS_W + 1;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  straps_t           straps_s, straps_q;
  logic              strobe_s;
  cpu_freq_e         code;

  assign raw_bus = {pwrgd_pd_n, fs_pins, sel_24_48, fsc_high};

  fsl_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({1'b1, {STRAPS_W{1'b0}}})
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  assign strobe_s = sync_bus[SYNC_W-1];
  assign straps_s = straps_t'(sync_bus[STRAPS_W-1:0]);

  fsl_capture capture_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_s (strobe_s),
    .straps_s (straps_s),
    .straps_q (straps_q),
    .locked   (locked),
    .pd_req   (pd_req)
  );

  fsl_decode decode_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .locked      (locked),
    .straps_q    (straps_q),
    .live_fsb    (straps_s.fs[1]),
    .code        (code),
    .invalid     (sel_invalid),
    .clk24_sel   (clk24_sel),
    .test_mode   (test_mode),
    .test_refdiv (test_refdiv)
  );

  assign cpu_freq_code = code;
endmodule

// File: tb/fsel_strap_latch_tb_top.sv
`timescale 1ns/1ps
module fsel_strap_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] fs_pins;
  logic       sel_24_48, fsc_high, pwrgd_pd_n;
  logic [2:0] cpu_freq_code;
  logic       sel_invalid, clk24_sel, test_mode, test_refdiv, pd_req, locked;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  fsel_strap_latch dut_i (
    .clk(clk), .rst_n(rst_n), .fs_pins(fs_pins), .sel_24_48(sel_24_48),
    .fsc_high(fsc_high), .pwrgd_pd_n(pwrgd_pd_n), .cpu_freq_code(cpu_freq_code),
    .sel_invalid(sel_invalid), .clk24_sel(clk24_sel), .test_mode(test_mode),
    .test_refdiv(test_refdiv), .pd_req(pd_req), .locked(locked)
  );

  function automatic int exp_code(input logic [3:0] dcba);
    case (dcba)
      4'b0101: return 0;
      4'b0001: return 1;
      4'b0011: return 2;
      4'b0010: return 3;
      4'b0000: return 4;
      4'b0100: return 5;
      4'b0110: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_inv(input logic [3:0] dcba);
    case (dcba)
      4'b0101, 4'b0001, 4'b0011, 4'b0010, 4'b0000, 4'b0100, 4'b0110: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwrgd_pd_n = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic check_unlocked(input string req);
    chk({req, " locked"}, locked, 0);
    chk({req, " pd_req"}, pd_req, 0);
    chk({req, " test_mode"}, test_mode, 0);
    chk({req, " refdiv"}, test_refdiv, 0);
    chk({req, " invalid"}, sel_invalid, 0);
    chk({req, " clk24"}, clk24_sel, 0);
    chk({req, " code"}, cpu_freq_code, 0);
  endtask

  task automatic check_latched(input logic [4:0] fs, input logic s24, input logic tst);
    chk("R2 locked", locked, 1);
    chk("R7 clk24_sel", clk24_sel, s24);
    chk("R8 test_mode", test_mode, tst);
    if (tst) begin
      chk("R8 code in test", cpu_freq_code, 0);
      chk("R8 invalid in test", sel_invalid, 0);
    end else begin
      chk("R5 code", cpu_freq_code, exp_code(fs[3:0]));
      chk("R6 invalid", sel_invalid, exp_inv(fs[3:0]));
      chk("R8 refdiv off", test_refdiv, 0);
    end
  endtask

  // Straps applied, strobe falls right after an edge and stays low.
  task automatic latch_with(input logic [4:0] fs, input logic s24, input logic tst);
    fs_pins = fs; sel_24_48 = s24; fsc_high = tst;
    cyc(3);
    pwrgd_pd_n = 1'b0;
    cyc(3);
    chk("R2 not yet locked", locked, 0);
    cyc(1);
    chk("R2 locked after fourth edge", locked, 1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; fs_pins = '0; sel_24_48 = 0; fsc_high = 0; pwrgd_pd_n = 1'b1;
    cyc(1);
    check_unlocked("R1 in reset");
    do_reset();
    check_unlocked("R1 after reset");

    // R2: one-cycle glitch low causes no latch
    fs_pins = 5'b00101;
    cyc(2);
    pwrgd_pd_n = 1'b0; cyc(1); pwrgd_pd_n = 1'b1;
    cyc(6);
    chk("R2 glitch ignored", locked, 0);
    // R4: strobe high before lock gives no power-down
    chk("R4 no pd before lock", pd_req, 0);

    // R5/R6: every {D,C,B,A}, FS_E random
    for (int v = 0; v < 16; v++) begin
      logic [4:0] fs;
      logic s24;
      do_reset();
      fs  = {1'($urandom), 4'(v)};
      s24 = 1'($urandom);
      latch_with(fs, s24, 1'b0);
      check_latched(fs, s24, 1'b0);
    end

    // Random scenarios: latch, then disturb pins
    for (int it = 0; it < 60; it++) begin
      logic [4:0] fs;
      logic s24, tst;
      do_reset();
      check_unlocked("R9 relock reset");
      fs  = 5'($urandom);
      s24 = 1'($urandom);
      tst = ($urandom % 4) == 0;
      latch_with(fs, s24, tst);
      check_latched(fs, s24, tst);
      // R4: strobe high requests power down, low releases it
      pwrgd_pd_n = 1'b1;
      cyc(1);
      chk("R4 pd delay", pd_req, 0);
      cyc(2);
      chk("R4 pd on", pd_req, 1);
      pwrgd_pd_n = 1'b0;
      cyc(3);
      chk("R4 pd off", pd_req, 0);
      // R3: change straps, latched outputs hold
      for (int k = 0; k < 3; k++) begin
        logic [4:0] nfs;
        nfs = 5'($urandom);
        fs_pins = nfs; sel_24_48 = 1'($urandom); fsc_high = 1'($urandom);
        pwrgd_pd_n = 1'($urandom);
        cyc(3);
        chk("R3 locked held", locked, 1);
        chk("R3 clk24 held", clk24_sel, s24);
        chk("R3 test held", test_mode, tst);
        if (tst) begin
          chk("R8 refdiv follows FS_B", test_refdiv, nfs[1]);
          chk("R3 code held test", cpu_freq_code, 0);
        end else begin
          chk("R3 code held", cpu_freq_code, exp_code(fs[3:0]));
          chk("R3 invalid held", sel_invalid, exp_inv(fs[3:0]));
          chk("R8 refdiv off", test_refdiv, 0);
        end
        pwrgd_pd_n = 1'b0;
        cyc(3);
      end
    end

    // R8 directed: test mode, FS_B toggled both ways
    do_reset();
    latch_with(5'b00000, 1'b1, 1'b1);
    fs_pins = 5'b00010; cyc(3);
    chk("R8 refdiv 1", test_refdiv, 1);
    fs_pins = 5'b00000; cyc(3);
    chk("R8 tristate 0", test_refdiv, 0);

    // R9: reset after lock clears it
    do_reset();
    check_unlocked("R9 after lock reset");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #900000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule